// File: doc/BRIEF.md
# Pulse-Qualified Overcurrent and Short-Circuit Trip Timer

This block decides when the low-side current of a synchronous buck stage has been too high for long enough to shut the converter down. Once per switching pulse, a fixed number of clock cycles after the low-side gate is turned on, it reads two comparator bits. One says the sensed current is above the overcurrent limit. The other says the current is above twice that limit. Each bit feeds its own window timer, which counts a 1 µs timebase. The overcurrent window is 20 µs and the short-circuit window is 10 µs.

A timer starts on the first sampled pulse that is over its limit. It is cancelled by any sampled pulse that is not over its limit. It trips when a sampled over-limit pulse arrives after the window has fully elapsed. Stretches with no pulses neither pass nor fail: the timer keeps its count and the decision waits for the next sample. A trip is latched. It reports which path fired so that the supervisor can shut the converter off and select its strongest power-good pull-down. Only the clear input releases the latch. The supervisor drives clear when enable drops or the supply falls below its power-on-reset level.

Top module: `octmr_top`

## Requirements
- R1: While and right after `rst` is high, `trip` is 0 and `trip_kind` is 2'b00.
- R2: The comparator bits are read only on the clock edge that comes exactly `BLANK_CYC` cycles after the edge on which `lg_rise` was seen high. Their values on any other cycle have no effect on `trip` or `trip_kind`.
- R3: The overcurrent timer starts on a sample with `cmp_oc`=1 and then counts `tick_us` strobes, saturating at `OC_WIN_US`. A later sample with `cmp_oc`=1 sets `trip`=1 with `trip_kind`=2'b01 if at least `OC_WIN_US` strobes have been counted. With fewer strobes counted, the sample sets nothing.
- R4: A sample with `cmp_oc`=0 cancels the overcurrent timer. The next over-limit sample starts a fresh count from zero.
- R5: `trip` changes from 0 to 1 only on a sampling edge. Strobes on `tick_us` with no pulses, however many, neither set nor cancel anything.
- R6: The short-circuit timer follows the same rules as R3 and R4, using `cmp_sc` and `SC_WIN_US`. When it fires it reports `trip_kind`=2'b10.
- R7: When both timers fire on the same sample, `trip_kind` is 2'b10.
- R8: Once `trip` is 1, it stays 1 and `trip_kind` stays unchanged until `clear` is asserted, whatever the later samples and strobes are.
- R9: `clear` drops `trip` to 0 and `trip_kind` to 2'b00 on the next edge, and takes precedence over a simultaneous trip. It also cancels both timers.
- R10: When `lg_rise` is seen again during the blanking delay, the delay restarts. Only the later pulse is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| lg_rise | input | 1 | One-cycle strobe on the low-side gate turn-on |
| cmp_oc | input | 1 | Sense current above the overcurrent limit |
| cmp_sc | input | 1 | Sense current above twice the overcurrent limit |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| clear | input | 1 | Releases the latched trip (enable low or supply below reset level) |
| trip | output | 1 | Latched fault: converter off, strongest power-good pull-down |
| trip_kind | output | 2 | 2'b01 overcurrent, 2'b10 short-circuit, 2'b00 none |

## Verification
The assertions take `lg_rise` and `tick_us` to be single-cycle strobes, and they take `clear` to be a level from the supervisor with no relation to the pulse timing. The stimulus keeps to this. It raises each strobe for exactly one cycle and never puts a microsecond strobe on a sampling edge, so every elapsed count is unambiguous. Between samples the comparator bits carry random values, which exercises the rule that they are ignored off the sampling edge.

// File: rtl/octmr_pkg.sv
package octmr_pkg;

    typedef enum logic [1:0] {
        TRIP_NONE = 2'b00,
        TRIP_OC   = 2'b01,
        TRIP_SC   = 2'b10
    } trip_kind_e;

    typedef struct packed {
        logic valid;
        logic over_oc;
        logic over_sc;
    } sample_t;

    localparam int NUM_PATHS = 2;
    localparam int PATH_OC   = 0;
    localparam int PATH_SC   = 1;

    // The short-circuit path outranks the overcurrent path.
    function automatic trip_kind_e pick_kind(input logic [NUM_PATHS-1:0] fired);
        if (fired[PATH_SC])
            return TRIP_SC;
        else if (fired[PATH_OC])
            return TRIP_OC;
        else
            return TRIP_NONE;
    endfunction

endpackage

// File: rtl/octmr_blank.sv
module octmr_blank
    import octmr_pkg::*;
#(
    parameter int BLANK_CYC = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    lg_rise,
    input  logic    cmp_oc,
    input  logic    cmp_sc,
    output sample_t samp
);
    localparam int BW = $clog2(BLANK_CYC + 1);

    logic [BW-1:0] dly_q;

    // A gate strobe reloads the delay, so a retrigger restarts blanking.
    always_ff @(posedge clk) begin
        if (rst)
            dly_q <= '0;
        else if (lg_rise)
            dly_q <= BW'(BLANK_CYC);
        else if (dly_q != '0)
            dly_q <= dly_q - 1'b1;
    end

    always_comb begin
        samp.valid   = (dly_q == BW'(1));
        samp.over_oc = cmp_oc;
        samp.over_sc = cmp_sc;
    end

endmodule

// File: rtl/octmr_window.sv
module octmr_window #(
    parameter int WIN_US = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic smp,
    input  logic over,
    input  logic tick,
    output logic fire
);
    localparam int CW = $clog2(WIN_US + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WIN_US);

    logic          armed_q;
    logic [CW-1:0] elapsed_q;
    logic          can_count;

    assign can_count = tick && (elapsed_q < LIMIT);
    assign fire      = smp && over && armed_q && (elapsed_q >= LIMIT);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            armed_q   <= 1'b0;
            elapsed_q <= '0;
        end else if (smp) begin
            if (!over) begin
                armed_q   <= 1'b0;
                elapsed_q <= '0;
            end else if (!armed_q) begin
                armed_q   <= 1'b1;
                elapsed_q <= '0;
            end else if (can_count) begin
                elapsed_q <= elapsed_q + 1'b1;
            end
        end else if (armed_q && can_count) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

endmodule

// File: rtl/octmr_latch.sv
module octmr_latch
    import octmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic [NUM_PATHS-1:0] fired,
    output logic                 trip,
    output trip_kind_e           kind
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            trip <= 1'b0;
            kind <= TRIP_NONE;
        end else if (!trip && (fired != '0)) begin
            trip <= 1'b1;
            kind <= pick_kind(fired);
        end
    end

endmodule

// File: rtl/octmr_top.sv
module octmr_top
    import octmr_pkg::*;
#(
    parameter int BLANK_CYC = 4,
    parameter int OC_WIN_US = 20,
    parameter int SC_WIN_US = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lg_rise,
    input  logic       cmp_oc,
    input  logic       cmp_sc,
    input  logic       tick_us,
    input  logic       clear,
    output logic       trip,
    output logic [1:0] trip_kind
);
    sample_t              samp;
    logic                 samp_stb;
    logic [NUM_PATHS-1:0] fired;
    logic [NUM_PATHS-1:0] over_vec;
    logic                 freeze;
    trip_kind_e           kind;

    octmr_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk     (clk),
        .rst     (rst),
        .lg_rise (lg_rise),
        .cmp_oc  (cmp_oc),
        .cmp_sc  (cmp_sc),
        .samp    (samp)
    );

    assign samp_stb         = samp.valid;
    assign over_vec[PATH_OC] = samp.over_oc;
    assign over_vec[PATH_SC] = samp.over_sc;
    assign freeze           = trip || clear;

    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
        localparam int WIN = (g == PATH_SC) ? SC_WIN_US : OC_WIN_US;
        octmr_window #(.WIN_US(WIN)) u_win (
            .clk  (clk),
            .rst  (rst),
            .hold (freeze),
            .smp  (samp_stb),
            .over (over_vec[g]),
            .tick (tick_us),
            .fire (fired[g])
        );
    end

    octmr_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .fired (fired),
        .trip  (trip),
        .kind  (kind)
    );

    assign trip_kind = kind;

endmodule

// File: rtl/octmr_checker.sv
module octmr_checker #(
    parameter int BLANK_CYC = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       lg_rise,
    input logic       clear,
    input logic       samp_stb,
    input logic       trip,
    input logic [1:0] trip_kind
);
    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!trip && trip_kind == 2'b00));

    // R5
    a_r5_set_on_sample: assert property (@(posedge clk) disable iff (rst)
        $rose(trip) |-> $past(samp_stb));

    // R8
    a_r8_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (trip && !clear) |=> (trip && $stable(trip_kind)));

    // R9
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!trip && trip_kind == 2'b00));

    // R3
    a_r3_kind_coded: assert property (@(posedge clk) disable iff (rst)
        trip |-> ($countones(trip_kind) == 1));

    // R3
    a_r3_idle_no_kind: assert property (@(posedge clk) disable iff (rst)
        !trip |-> (trip_kind == 2'b00));

    if (BLANK_CYC > 1) begin : g_blank
        // R10
        a_r10_no_early_sample: assert property (@(posedge clk) disable iff (rst)
            lg_rise |=> !samp_stb);
    end

endmodule

bind octmr_top octmr_checker #(.BLANK_CYC(BLANK_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lg_rise   (lg_rise),
    .clear     (clear),
    .samp_stb  (samp_stb),
    .trip      (trip),
    .trip_kind (trip_kind)
);

// File: tb/octmr_top_test.sv
module octmr_top_test;
    localparam int BLANK = 4;
    localparam int OCW   = 20;
    localparam int SCW   = 10;

    logic clk = 1'b0;
    logic rst, lg_rise, cmp_oc, cmp_sc, tick_us, clear;
    logic       trip;
    logic [1:0] trip_kind;

    int checks = 0;
    int failures = 0;
    int seed_init;

    // reference model state
    bit m_oc_arm, m_sc_arm, m_trip;
    int m_oc_el, m_sc_el;
    logic [1:0] m_kind;

    octmr_top #(.BLANK_CYC(BLANK), .OC_WIN_US(OCW), .SC_WIN_US(SCW)) uut (
        .clk(clk), .rst(rst), .lg_rise(lg_rise), .cmp_oc(cmp_oc), .cmp_sc(cmp_sc),
        .tick_us(tick_us), .clear(clear), .trip(trip), .trip_kind(trip_kind)
    );

    always #2.5 clk = ~clk;

    function automatic logic [1:0] exp_kind(input bit oc_f, input bit sc_f);
        if (sc_f) return 2'b10;
        if (oc_f) return 2'b01;
        return 2'b00;
    endfunction

    function automatic bit path_fires(input bit arm, input int el, input bit over, input int win);
        return arm && over && (el >= win);
    endfunction

    task automatic model_reset();
        m_oc_arm = 0; m_sc_arm = 0; m_oc_el = 0; m_sc_el = 0;
        m_trip = 0; m_kind = 2'b00;
    endtask

    task automatic model_tick();
        if (m_trip) return;
        if (m_oc_arm && m_oc_el < OCW) m_oc_el++;
        if (m_sc_arm && m_sc_el < SCW) m_sc_el++;
    endtask

    task automatic model_sample(input bit oc, input bit sc);
        bit oc_f, sc_f;
        if (m_trip) return;
        oc_f = path_fires(m_oc_arm, m_oc_el, oc, OCW);
        sc_f = path_fires(m_sc_arm, m_sc_el, sc, SCW);
        if (oc_f || sc_f) begin
            m_trip = 1; m_kind = exp_kind(oc_f, sc_f);
            m_oc_arm = 0; m_sc_arm = 0; m_oc_el = 0; m_sc_el = 0;
            return;
        end
        if (!oc) begin m_oc_arm = 0; m_oc_el = 0; end
        else if (!m_oc_arm) begin m_oc_arm = 1; m_oc_el = 0; end
        if (!sc) begin m_sc_arm = 0; m_sc_el = 0; end
        else if (!m_sc_arm) begin m_sc_arm = 1; m_sc_el = 0; end
    endtask

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s trip/kind actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_model(input string req);
        check(req, {trip, trip_kind}, {m_trip, m_kind});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_us = 1'b1;
            @(negedge clk) tick_us = 1'b0;
            model_tick();
        end
    endtask

    // one gate pulse; comparators carry noise except on the sampling edge (R2)
    task automatic pulse(input bit oc, input bit sc, input string req);
        @(negedge clk);
        lg_rise = 1'b1; cmp_oc = ~oc; cmp_sc = ~sc;
        @(negedge clk);
        lg_rise = 1'b0; cmp_oc = 1'($urandom); cmp_sc = 1'($urandom);
        repeat (BLANK - 1) begin
            @(negedge clk);
            cmp_oc = ~oc; cmp_sc = ~sc;
        end
        cmp_oc = oc; cmp_sc = sc;
        @(negedge clk);
        cmp_oc = ~oc; cmp_sc = ~sc;
        model_sample(oc, sc);
        check_model(req);
    endtask

    task automatic do_clear(input string req);
        @(negedge clk) clear = 1'b1;
        @(negedge clk) clear = 1'b0;
        model_reset();
        check(req, {trip, trip_kind}, 3'b000);
    endtask

    // R10: retrigger two cycles in; only the late sample may count
    task automatic retrig_pulse(input bit oc);
        @(negedge clk) lg_rise = 1'b1; cmp_oc = ~oc; cmp_sc = 1'b0;
        @(negedge clk) lg_rise = 1'b0;
        @(negedge clk) lg_rise = 1'b1;
        @(negedge clk) lg_rise = 1'b0;
        repeat (BLANK - 1) @(negedge clk);
        cmp_oc = oc;
        @(negedge clk) cmp_oc = ~oc;
        model_sample(oc, 1'b0);
        check_model("R10 retrigger sample");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        seed_init = $urandom(32'h0c7e_5eed);
        rst = 1'b1; lg_rise = 0; cmp_oc = 0; cmp_sc = 0; tick_us = 0; clear = 0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 in reset", {trip, trip_kind}, 3'b000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {trip, trip_kind}, 3'b000);

        // R3 boundary: one strobe short, then exact window
        pulse(1, 0, "R3 arm");
        ticks(OCW - 1);
        pulse(1, 0, "R3 one short");
        check("R3 no early trip", {trip, trip_kind}, 3'b000);
        ticks(1);
        pulse(1, 0, "R3 exact window");
        check("R3 overcurrent trip", {trip, trip_kind}, 3'b101);
        // R8: later pulses and strobes change nothing
        pulse(1, 1, "R8 latched");
        ticks(30);
        pulse(1, 1, "R8 latched after time");
        check("R8 kind held", {trip, trip_kind}, 3'b101);
        do_clear("R9 clear");
        // R9: timers cancelled too
        pulse(1, 0, "R9 rearm after clear");

        // R4: passing pulse restarts the window
        do_clear("R9 clear");
        pulse(1, 0, "R4 arm");
        ticks(15);
        pulse(0, 0, "R4 passing pulse");
        pulse(1, 0, "R4 rearm");
        ticks(10);
        pulse(1, 0, "R4 would trip without reset");
        check("R4 no trip", {trip, trip_kind}, 3'b000);

        // R5: long gap with no pulses decides nothing
        ticks(50);
        check("R5 gap no trip", {trip, trip_kind}, 3'b000);
        pulse(1, 0, "R5 decide on next sample");
        check("R5 trip after gap", {trip, trip_kind}, 3'b101);

        // R6: short-circuit path
        do_clear("R9 clear");
        pulse(1, 1, "R6 arm");
        ticks(SCW - 1);
        pulse(1, 1, "R6 one short");
        pulse(1, 0, "R6 sc restart");
        pulse(1, 1, "R6 sc rearm");
        ticks(SCW);
        pulse(1, 1, "R6 short-circuit trip");
        check("R6 kind sc", {trip, trip_kind}, 3'b110);

        // R7: both fire together
        do_clear("R9 clear");
        pulse(1, 1, "R7 arm both");
        ticks(OCW);
        pulse(1, 1, "R7 both fire");
        check("R7 sc wins", {trip, trip_kind}, 3'b110);

        // R10: retrigger during blanking
        do_clear("R9 clear");
        pulse(1, 0, "R10 arm");
        ticks(OCW);
        retrig_pulse(1'b1);
        check("R10 trip from late sample", {trip, trip_kind}, 3'b101);

        // R9: clear on the same edge as a firing sample
        do_clear("R9 clear");
        pulse(1, 0, "R9 arm");
        ticks(OCW);
        @(negedge clk) lg_rise = 1'b1;
        @(negedge clk) lg_rise = 1'b0;
        repeat (BLANK - 1) @(negedge clk);
        cmp_oc = 1'b1; clear = 1'b1;
        @(negedge clk) clear = 1'b0; cmp_oc = 1'b0;
        model_reset();
        check("R9 clear beats trip", {trip, trip_kind}, 3'b000);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom_range(0, 19));
            if (op < 12) begin
                bit sc_v, oc_v;
                sc_v = ($urandom_range(0, 3) != 0);
                oc_v = sc_v ? 1'b1 : ($urandom_range(0, 4) != 0);
                pulse(oc_v, sc_v, "R2/R3/R6 random pulse");
            end else if (op < 19) begin
                ticks(int'($urandom_range(0, 6)));
            end else begin
                do_clear("R9 random clear");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule